// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Graceful Channel Disable

This block is a full-duplex asynchronous serial port. Bytes written into a 16-entry transmit queue are sent on `txd` one frame at a time. Frames arriving on `rxd` are rebuilt into bytes and stored, each with a framing-error bit, in a 16-entry receive queue. A 16-bit divisor sets the oversampling tick. Each bit on the line lasts 16 ticks, so the bit time is 16 × divisor clock cycles. The frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line rests high.

A three-bit control register enables the channels. Bit 0 is the global enable, bit 1 the transmit enable and bit 2 the receive enable. All three are set after reset. A direction runs only while its own bit and the global bit are both set. Clearing an enable never cuts a frame short: the frame in progress finishes, and only then does the direction stop starting new frames. The divisor can be changed only while the global enable is clear.

The transmitter state machine has four states. TX_IDLE goes to TX_START when it is enabled and its queue is not empty; this transition pops the queue. TX_START goes to TX_DATA after 16 ticks. TX_DATA goes to TX_STOP after its eighth bit. TX_STOP returns to TX_IDLE after 16 ticks. The receiver has four states. RX_IDLE goes to RX_START on a high-to-low edge of the synchronized line while it is enabled. RX_START goes to RX_DATA if the line is still low at the eighth tick, and otherwise falls back to RX_IDLE. RX_DATA goes to RX_STOP after eight mid-bit samples. RX_STOP returns to RX_IDLE at the middle of the stop bit, which is where it stores the byte.

Top module: `uart_core`

## Requirements
- R1: After reset, `ctrl_q` is 3'b111, `div_q` is 1, both queues are empty and not full, `txd` is 1 and `tx_busy` is 0.
- R2: A transmitted frame is one 0 start bit, then the eight data bits LSB first, then one 1 stop bit. Each bit lasts 16 × `div_q` clock cycles.
- R3: A well-formed frame received on `rxd` appears at the head of the receive queue (`rx_rdata`) with `rx_ferr` at 0.
- R4: A frame whose stop bit is sampled low is stored with `rx_ferr` at 1.
- R5: The receiver starts a frame only on a high-to-low edge, and only if the line is still low at the middle of the start bit. A low pulse shorter than half a bit stores nothing.
- R6: A write to `div_wdata` is ignored while `ctrl_q[0]` is 1 and takes effect while `ctrl_q[0]` is 0.
- R7: Clearing `ctrl_q[0]` during a frame lets both directions finish their current frame. After that, `txd` stays 1, `tx_busy` stays 0 and queued transmit bytes are held until the channel is enabled again.
- R8: While `ctrl_q[2]` is 0, frames on `rxd` are not received.
- R9: Each queue holds exactly 16 bytes. A write into a full queue is dropped, and the stored bytes come out in write order.
- R10: `tx_busy` is 1 for the whole of a transmit frame, and `txd` is low only while `tx_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 3 | Enables: bit 0 global, bit 1 transmit, bit 2 receive |
| div_we | input | 1 | Write strobe for the divisor (accepted only while global enable is 0) |
| div_wdata | input | 16 | New divisor value |
| ctrl_q | output | 3 | Current control register |
| div_q | output | 16 | Current divisor |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_busy | output | 1 | Transmit frame on the line |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 8 | Byte at the head of the receive queue |
| rx_ferr | output | 1 | Framing-error bit of the head entry |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The bench clears the global enable in the middle of a frame. A design that halted at once would leave a truncated byte on the line and in the receive queue, and a design that ignored the clear would go straight on to send the second queued byte. It sends a four-cycle low pulse and a frame with a low stop bit. A receiver without the mid-start check would store a phantom byte, and one that armed on a low level instead of an edge would re-trigger inside the bad stop bit. It tries a divisor write while the channel is enabled, where a missing lock would stretch the bit period. It fills the transmit queue with seventeen bytes, where pointer wrap-around would corrupt the order or the count.

// File: rtl/uart_core_pkg.sv
package uart_core_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
    localparam int CTRL_W      = 3;
    localparam int CTRL_GLOBAL = 0;
    localparam int CTRL_TX     = 1;
    localparam int CTRL_RX     = 2;
    localparam int OVS         = 16;
    localparam int DATA_W      = 8;
endpackage

// File: rtl/uart_baud.sv
module uart_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // divisor 0 behaves like 1
    assign tick = ({1'b0, cnt} + 1'b1) >= {1'b0, div};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         rd,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          do_wr, do_rd;

    assign full  = cnt == (AW+1)'(DEPTH);
    assign empty = cnt == '0;
    assign do_wr = wr && !full;
    assign do_rd = rd && !empty;
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R9: a write into a full queue is dropped, so it stays full
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd) |=> full);
    // R9: a read from an empty queue leaves it empty
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd && !wr) |=> empty);
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd,
    output logic              busy
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    tx_state_e         state, state_d;
    logic [SUB_W-1:0]  sub, sub_d;
    logic [BIT_W-1:0]  bitn, bitn_d;
    logic [DATA_W-1:0] shreg, shreg_d;
    logic              bit_end;

    assign bit_end = tick && (sub == SUB_W'(OVS-1));

    always_comb begin
        state_d = state;
        sub_d   = sub;
        bitn_d  = bitn;
        shreg_d = shreg;
        unique case (state)
            TX_IDLE: if (en && !q_empty) begin
                state_d = TX_START;
                sub_d   = '0;
                shreg_d = q_data;
            end
            TX_START: if (bit_end) begin
                state_d = TX_DATA;
                sub_d   = '0;
                bitn_d  = '0;
            end else if (tick) sub_d = sub + 1'b1;
            TX_DATA: if (bit_end) begin
                shreg_d = shreg >> 1;
                bitn_d  = bitn + 1'b1;
                sub_d   = '0;
                if (bitn == BIT_W'(DATA_W-1)) state_d = TX_STOP;
            end else if (tick) sub_d = sub + 1'b1;
            TX_STOP: if (bit_end) state_d = TX_IDLE;
                     else if (tick) sub_d = sub + 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            state <= state_d;
            sub   <= sub_d;
            bitn  <= bitn_d;
            shreg <= shreg_d;
        end
    end

    always_comb begin
        q_pop = (state == TX_IDLE) && en && !q_empty;
        busy  = state != TX_IDLE;
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    // R7: no frame starts while the direction is disabled
    a_r7_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && !en) |=> !busy);
    // R10: the line is driven low only during a frame
    a_r10_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !txd |-> busy);
    // R2: a frame ends only from its stop bit
    a_r2_ends_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(state == TX_STOP));
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_core_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              en,
    input  logic              rxd,
    output logic              push,
    output logic [DATA_W-1:0] pdata,
    output logic              pferr
);
    localparam int SUB_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    rx_state_e         state, state_d;
    logic [SUB_W-1:0]  sub, sub_d;
    logic [BIT_W-1:0]  bitn, bitn_d;
    logic [DATA_W-1:0] shreg, shreg_d;
    logic              sync1, rxs, rxs_d;
    logic              bit_end, mid_start;

    assign bit_end   = tick && (sub == SUB_W'(OVS-1));
    assign mid_start = tick && (sub == SUB_W'(OVS/2-1));

    always_comb begin
        state_d = state;
        sub_d   = sub;
        bitn_d  = bitn;
        shreg_d = shreg;
        unique case (state)
            RX_IDLE: if (en && !rxs && rxs_d) begin
                state_d = RX_START;
                sub_d   = '0;
            end
            RX_START: if (mid_start) begin
                state_d = rxs ? RX_IDLE : RX_DATA;
                sub_d   = '0;
                bitn_d  = '0;
            end else if (tick) sub_d = sub + 1'b1;
            RX_DATA: if (bit_end) begin
                shreg_d = {rxs, shreg[DATA_W-1:1]};
                bitn_d  = bitn + 1'b1;
                sub_d   = '0;
                if (bitn == BIT_W'(DATA_W-1)) state_d = RX_STOP;
            end else if (tick) sub_d = sub + 1'b1;
            RX_STOP: if (bit_end) state_d = RX_IDLE;
                     else if (tick) sub_d = sub + 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            sync1 <= 1'b1;
            rxs   <= 1'b1;
            rxs_d <= 1'b1;
        end else begin
            state <= state_d;
            sub   <= sub_d;
            bitn  <= bitn_d;
            shreg <= shreg_d;
            sync1 <= rxd;
            rxs   <= sync1;
            rxs_d <= rxs;
        end
    end

    always_comb begin
        push  = (state == RX_STOP) && bit_end;
        pdata = shreg;
        pferr = !rxs;
    end

    // R8: a disabled receiver does not leave idle
    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !en) |=> state == RX_IDLE);
    // R5: a frame begins only on a falling edge of the synchronized line
    a_r5_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && state_d == RX_START) |-> (!rxs && rxs_d));
endmodule

// File: rtl/uart_core.sv
module uart_core
    import uart_core_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DIV_RESET  = 1,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DIV_W-1:0]  div_q,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_busy,
    output logic              txd,
    input  logic              rxd,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_rdata,
    output logic              rx_ferr,
    output logic              rx_full,
    output logic              rx_empty
);
    logic              tick, en_tx, en_rx, tx_pop, rx_push, rx_pferr;
    logic [DATA_W-1:0] tx_head, rx_pdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '1;
            div_q  <= DIV_W'(DIV_RESET);
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata;
            if (div_we && !ctrl_q[CTRL_GLOBAL]) div_q <= div_wdata;
        end
    end

    assign en_tx = ctrl_q[CTRL_GLOBAL] && ctrl_q[CTRL_TX];
    assign en_rx = ctrl_q[CTRL_GLOBAL] && ctrl_q[CTRL_RX];

    uart_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick));

    uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_wdata),
        .rd(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_tx),
        .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
        .txd(txd), .busy(tx_busy));

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en_rx), .rxd(rxd),
        .push(rx_push), .pdata(rx_pdata), .pferr(rx_pferr));

    uart_fifo #(.W(DATA_W+1), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .wr(rx_push), .wdata({rx_pferr, rx_pdata}),
        .rd(rx_rd), .rdata({rx_ferr, rx_rdata}), .full(rx_full), .empty(rx_empty));

    // R6: the divisor is frozen while the global enable is set
    a_r6_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[CTRL_GLOBAL] && $past(ctrl_q[CTRL_GLOBAL])) |-> $stable(div_q));
endmodule

// File: tb/tb_uart_core.sv
module tb_uart_core;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h55, 8'hA3, 8'h00, 8'hFF, 8'h01, 8'h80};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ctrl_we = 1'b0, div_we = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [2:0]  ctrl_wdata = '0, ctrl_q;
    logic [15:0] div_wdata = '0, div_q;
    logic [7:0]  tx_wdata = '0, rx_rdata;
    logic        tx_full, tx_empty, tx_busy, txd, rx_ferr, rx_full, rx_empty;
    logic        loop = 1'b1, drv = 1'b1, rxd;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    assign rxd = loop ? txd : drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_core dut (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .div_we(div_we), .div_wdata(div_wdata), .ctrl_q(ctrl_q), .div_q(div_q),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .rx_ferr(rx_ferr), .rx_full(rx_full), .rx_empty(rx_empty));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic [2:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v; @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic set_div(input logic [15:0] v);
        div_we = 1'b1; div_wdata = v; @(negedge clk); div_we = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] v);
        tx_wr = 1'b1; tx_wdata = v; @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pop_rx();
        rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_rx(input int limit);
        for (int i = 0; i < limit && rx_empty; i++) @(negedge clk);
    endtask

    task automatic wait_fall(input int limit);
        for (int i = 0; i < limit && txd; i++) @(negedge clk);
    endtask

    // bench-driven frame, 16 cycles per bit (divisor 1), then two idle bits
    task automatic send_frame(input logic [7:0] v, input logic stop);
        drv = 1'b0; wait_clk(16);
        for (int i = 0; i < 8; i++) begin drv = v[i]; wait_clk(16); end
        drv = stop; wait_clk(16);
        drv = 1'b1; wait_clk(32);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        // R1 reset state
        check("R1 ctrl", ctrl_q, 3'b111);
        check("R1 div", div_q, 16'd1);
        check("R1 empties", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        check("R1 line", {txd, tx_busy}, 2'b10);

        // R3 loopback vector table
        for (int k = 0; k < NVEC; k++) begin
            push_tx(VEC[k]);
            wait_rx(400);
            check("R3 data", rx_rdata, VEC[k]);
            check("R3 ferr", rx_ferr, 1'b0);
            pop_rx();
        end

        // R2 / R10 bit-level frame shape
        push_tx(8'hA5);
        wait_fall(100);
        check("R10 busy at start", tx_busy, 1'b1);
        wait_clk(8);
        check("R2 start bit", txd, 1'b0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(16);
            check("R2 data bit", txd, 1'(8'hA5 >> i));
        end
        wait_clk(16);
        check("R2 stop bit", txd, 1'b1);
        check("R10 busy in stop", tx_busy, 1'b1);
        wait_rx(100);
        check("R3 A5", rx_rdata, 8'hA5);
        pop_rx();
        wait_clk(20);
        check("R10 idle after", {tx_busy, txd}, 2'b01);

        // R6 divisor lock
        set_div(16'd5);
        wait_clk(1);
        check("R6 locked", div_q, 16'd1);
        set_ctrl(3'b110);
        set_div(16'd2);
        set_ctrl(3'b111);
        check("R6 accepted", div_q, 16'd2);
        push_tx(8'hFF);
        wait_fall(100);
        wait_clk(24);
        check("R6 doubled start bit", txd, 1'b0);
        wait_rx(700);
        check("R6 data at div 2", rx_rdata, 8'hFF);
        pop_rx();
        set_ctrl(3'b110);
        set_div(16'd1);
        set_ctrl(3'b111);

        // R7 graceful disable mid-frame
        push_tx(8'h3C);
        push_tx(8'hC3);
        wait_fall(100);
        wait_clk(40);
        set_ctrl(3'b110);
        check("R7 busy after disable", tx_busy, 1'b1);
        wait_clk(160);
        check("R7 frame done", {tx_busy, txd, tx_empty}, 3'b010);
        check("R7 rx finished", {rx_empty, rx_rdata}, {1'b0, 8'h3C});
        pop_rx();
        wait_clk(200);
        check("R7 held", {tx_busy, txd, tx_empty, rx_empty}, 4'b0101);
        set_ctrl(3'b111);
        wait_rx(400);
        check("R7 resumed", rx_rdata, 8'hC3);
        pop_rx();

        // R8 receiver disabled
        loop = 1'b0;
        set_ctrl(3'b011);
        send_frame(8'h5A, 1'b1);
        check("R8 ignored", rx_empty, 1'b1);
        set_ctrl(3'b111);
        send_frame(8'h5A, 1'b1);
        check("R3 driven frame", {rx_empty, rx_ferr, rx_rdata}, {2'b00, 8'h5A});
        pop_rx();

        // R4 framing error, no phantom frame after it
        send_frame(8'h81, 1'b0);
        check("R4 ferr", {rx_empty, rx_ferr, rx_rdata}, {2'b01, 8'h81});
        pop_rx();
        wait_clk(2);
        check("R4 single entry", rx_empty, 1'b1);

        // R5 glitch rejection
        drv = 1'b0; wait_clk(4); drv = 1'b1;
        wait_clk(60);
        check("R5 glitch", rx_empty, 1'b1);

        // R9 depth and drop on full
        loop = 1'b1;
        set_ctrl(3'b101);
        for (int i = 0; i < 17; i++) begin
            push_tx(8'(i));
            if (i == 15) check("R9 full at 16", tx_full, 1'b1);
        end
        check("R9 held while off", {tx_full, tx_busy, txd}, 3'b101);
        set_ctrl(3'b111);
        for (int i = 0; i < 4000 && !rx_full; i++) @(negedge clk);
        wait_clk(200);
        check("R9 rx full", {rx_full, tx_empty, tx_busy}, 3'b110);
        for (int i = 0; i < 16; i++) begin
            check("R9 order", rx_rdata, 8'(i));
            pop_rx();
        end
        check("R9 drained", rx_empty, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule